// File: doc/BRIEF.md
# GPIO Controller with Atomic Set/Clear Writes

This block drives and senses 28 general-purpose pins over a simple 32-bit register port. The pins form two banks: pins 0 to 15 in the lower bank and pins 16 to 27 in the upper bank. Each upper-bank register sits 0x80 above its lower-bank twin. The output-value and output-enable registers are never written as plain values. Each write carries a set mask in its lower half and a clear mask in its upper half, so software can flip one pin without reading the register first, and a concurrent write to a different pin cannot undo it.

Four event-routing registers give every pin a 4-bit field. The field names one of eight event pairs and says whether the pin raises a power-management event or an ordinary interrupt. These fields are plain read/write storage and are exported on a flat port, so downstream routing logic can consume them. Reads are combinational from the address. Writes take effect on the next rising clock edge.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset the output-value, output-enable and event-routing registers all hold zero, so `pin_out`, `pin_oe` and `ev_map` are zero.
- R2: In a write to a value register (0x00 lower, 0x80 upper) or an enable register (0x04 lower, 0x84 upper), a 1 in bit k (0 to 15) sets pin k of the addressed bank. Pins whose set and clear bits are both 0 keep their state.
- R3: In the same kind of write, a 1 in bit 16+k clears pin k of the addressed bank.
- R4: When one write has both bit k and bit 16+k set, pin k ends up cleared.
- R5: The upper-bank registers sit at the lower-bank offset plus 0x80 and cover pins 16 to 27 as bank bits 0 to 11. Bank bits 12 to 15 of the upper bank are ignored on write and read as 0.
- R6: Reading a value or enable register returns the bank's pin states in bits 15:0, with bits 31:16 read as 0.
- R7: The input registers (0x08 lower, 0x88 upper) return `pin_in` for the bank in bits 15:0. Writes to them change nothing.
- R8: `pin_oe` equals the enable state. `pin_out` carries the value state only on pins whose enable bit is 1, and is 0 elsewhere.
- R9: The event-routing registers at 0x40, 0x44, 0x48 and 0x4C hold pins 0–7, 8–15, 16–23 and 24–27. They are plain read/write registers. Pin p uses bits (p mod 8)*4+3 down to (p mod 8)*4. In each field, bits 2:0 pick the event pair and bit 3 set means power-management event. The fields appear on `ev_map[4p+3:4p]`, and bits 31:16 of register 0x4C read as 0.
- R10: Reads from any other offset return 0, and writes to them leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data (set mask low, clear mask high for banked registers) |
| rdata | output | 32 | Combinational read data for `addr` |
| pin_in | input | 28 | Sensed pin levels |
| pin_out | output | 28 | Driven pin levels, gated by enable |
| pin_oe | output | 28 | Per-pin output enable |
| ev_map | output | 112 | Per-pin 4-bit event-routing fields |

## Verification
The bench builds the block with its default values: 28 pins and an 8-bit offset. With these values the upper bank is only partly populated, so the ignored bank bits 12 to 15 and the half-empty last routing register are both reachable. A vector table walks set, clear and set-with-clear writes on both banks. The enable and routing registers, the read-only inputs and an unmapped offset are covered too. Directed steps then check the gated pin outputs, the exported routing fields and a second reset taken in mid-run.

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int NUM_PINS  = 28,
  parameter int ADDR_W    = 8,
  parameter int HIGH_OFS  = 'h80,
  parameter int MAP_BASE  = 'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [4*NUM_PINS-1:0] ev_map
);

  localparam int BANK_W   = 16;
  localparam int MAP_REGS = (NUM_PINS + 7) / 8;
  localparam int OFS_VAL  = 'h00;
  localparam int OFS_OE   = 'h04;
  localparam int OFS_IN   = 'h08;

  logic [NUM_PINS-1:0] val_q, oe_q;
  logic [3:0]          map_q [NUM_PINS];

  logic sel_val_lo, sel_val_hi, sel_oe_lo, sel_oe_hi, sel_in_lo, sel_in_hi;
  logic map_hit, unmapped;
  logic [ADDR_W-1:0] map_off;

  assign sel_val_lo = addr == ADDR_W'(OFS_VAL);
  assign sel_val_hi = addr == ADDR_W'(HIGH_OFS + OFS_VAL);
  assign sel_oe_lo  = addr == ADDR_W'(OFS_OE);
  assign sel_oe_hi  = addr == ADDR_W'(HIGH_OFS + OFS_OE);
  assign sel_in_lo  = addr == ADDR_W'(OFS_IN);
  assign sel_in_hi  = addr == ADDR_W'(HIGH_OFS + OFS_IN);
  assign map_off    = addr - ADDR_W'(MAP_BASE);
  assign map_hit    = (addr >= ADDR_W'(MAP_BASE)) &&
                      (addr <  ADDR_W'(MAP_BASE + 4 * MAP_REGS)) &&
                      (addr[1:0] == 2'b00);
  assign unmapped   = !(sel_val_lo || sel_val_hi || sel_oe_lo || sel_oe_hi ||
                        sel_in_lo || sel_in_hi || map_hit);

  function automatic logic [NUM_PINS-1:0] apply_sc(input logic [NUM_PINS-1:0] cur,
                                                   input logic [31:0] w,
                                                   input logic hi);
    logic [NUM_PINS-1:0] nxt;
    int base;
    nxt  = cur;
    base = hi ? BANK_W : 0;
    for (int k = 0; k < BANK_W; k++) begin
      if (k + base < NUM_PINS) begin
        if (w[BANK_W + k])  nxt[k + base] = 1'b0;
        else if (w[k])      nxt[k + base] = 1'b1;
      end
    end
    return nxt;
  endfunction

  function automatic logic [31:0] bank_view(input logic [NUM_PINS-1:0] v, input logic hi);
    logic [31:0] r;
    int base;
    r    = '0;
    base = hi ? BANK_W : 0;
    for (int k = 0; k < BANK_W; k++)
      if (k + base < NUM_PINS) r[k] = v[k + base];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      oe_q  <= '0;
      for (int p = 0; p < NUM_PINS; p++) map_q[p] <= 4'h0;
    end else if (wr_en) begin
      if (sel_val_lo) val_q <= apply_sc(val_q, wdata, 1'b0);
      if (sel_val_hi) val_q <= apply_sc(val_q, wdata, 1'b1);
      if (sel_oe_lo)  oe_q  <= apply_sc(oe_q,  wdata, 1'b0);
      if (sel_oe_hi)  oe_q  <= apply_sc(oe_q,  wdata, 1'b1);
      if (map_hit)
        for (int p = 0; p < NUM_PINS; p++)
          if (map_off[ADDR_W-1:2] == (ADDR_W-2)'(p / 8))
            map_q[p] <= wdata[(p % 8) * 4 +: 4];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_val_lo)      rdata = bank_view(val_q,  1'b0);
    else if (sel_val_hi) rdata = bank_view(val_q,  1'b1);
    else if (sel_oe_lo)  rdata = bank_view(oe_q,   1'b0);
    else if (sel_oe_hi)  rdata = bank_view(oe_q,   1'b1);
    else if (sel_in_lo)  rdata = bank_view(pin_in, 1'b0);
    else if (sel_in_hi)  rdata = bank_view(pin_in, 1'b1);
    else if (map_hit)
      for (int p = 0; p < NUM_PINS; p++)
        if (map_off[ADDR_W-1:2] == (ADDR_W-2)'(p / 8))
          rdata[(p % 8) * 4 +: 4] = map_q[p];
  end

  assign pin_oe  = oe_q;
  assign pin_out = val_q & oe_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    assign ev_map[4*p +: 4] = map_q[p];
  end

  AST_SET_LOW_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_val_lo && wdata[0] && !wdata[16]) |=> val_q[0]);                 // R2
  AST_CLEAR_HIGH_PIN16: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_val_hi && wdata[16]) |=> !val_q[16]);                            // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_oe_lo && wdata[0] && wdata[16]) |=> !pin_oe[0]);                 // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(val_q) && $stable(oe_q)));                                 // R2
  AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(ev_map))); // R10
  AST_INPUT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel_in_lo || sel_in_hi)) |=> ($stable(pin_oe) && $stable(pin_out))); // R7

endmodule

// File: tb/sim_gpio_setclr_bank.sv
module sim_gpio_setclr_bank;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [27:0]  pin_in = 28'h9AB_CDEF;
  logic [27:0]  pin_out, pin_oe;
  logic [111:0] ev_map;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_setclr_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ev_map(ev_map)
  );

  // {write offset, write data, expected read-back of the same offset}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'h0000_0005, 32'h0000_0005},  // R2 set pins 0,2
    {8'h00, 32'h0001_0002, 32'h0000_0006},  // R2 R3 clear 0, set 1, keep 2
    {8'h00, 32'h0004_0004, 32'h0000_0002},  // R4 clear beats set on pin 2
    {8'h80, 32'h0000_F00F, 32'h0000_000F},  // R5 upper bank, bits 12-15 ignored
    {8'h80, 32'h0003_0000, 32'h0000_000C},  // R3 R5 clear pins 16,17
    {8'h04, 32'h0000_0003, 32'h0000_0003},  // R6 lower enables
    {8'h84, 32'h0000_0008, 32'h0000_0008},  // R6 upper enable pin 19
    {8'h40, 32'h8765_4321, 32'h8765_4321},  // R9 map pins 0-7
    {8'h4C, 32'hFFFF_ABCD, 32'h0000_ABCD},  // R9 map pins 24-27 only
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
    {8'h08, 32'hFFFF_FFFF, 32'h0000_CDEF},  // R7 lower inputs
    {8'h88, 32'hFFFF_FFFF, 32'h0000_09AB}   // R7 upper inputs
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R1 pin_oe", 128'(pin_oe), 0);
    check("R1 pin_out", 128'(pin_out), 0);
    check("R1 ev_map", 128'(ev_map), 0);
    rst_n = 1;
    read_reg(8'h00, r); check("R1 value reg", 128'(r), 0);
    read_reg(8'h84, r); check("R1 enable reg", 128'(r), 0);

    for (int i = 0; i < NV; i++) begin
      write_reg(VEC[i][71:64], VEC[i][63:32]);
      read_reg(VEC[i][71:64], r);
      check($sformatf("vector %0d (R2-R10 table)", i), 128'(r), 128'(VEC[i][31:0]));
    end

    read_reg(8'h00, r); check("R10 value kept after unmapped write", 128'(r), 128'h2);
    read_reg(8'h80, r); check("R7 upper value kept after input write", 128'(r), 128'hC);
    check("R8 pin_oe", 128'(pin_oe), 128'h008_0003);
    check("R8 pin_out gated", 128'(pin_out), 128'h008_0002);
    check("R9 pin0 field", 128'(ev_map[3:0]), 128'h1);
    check("R9 pin7 PME field", 128'(ev_map[31:28]), 128'h8);
    check("R9 pin24 field", 128'(ev_map[99:96]), 128'hD);
    check("R9 pin27 field", 128'(ev_map[111:108]), 128'hA);
    check("R9 pins 8-23 untouched", 128'(ev_map[95:32]), 0);

    write_reg(8'h44, 32'h0000_00F0);
    read_reg(8'h44, r); check("R9 map pins 8-15", 128'(r), 128'hF0);
    check("R9 pin9 field", 128'(ev_map[39:36]), 128'hF);

    write_reg(8'h04, 32'hFFFF_0000);
    check("R3 enable cleared, outputs gated", 128'(pin_out), 128'h008_0000);
    read_reg(8'h4C, r); check("R9 map upper half reads zero", 128'(r), 128'hABCD);

    @(negedge clk); rst_n = 0;
    #1;
    check("R1 mid-run reset pin_oe", 128'(pin_oe), 0);
    check("R1 mid-run reset ev_map", 128'(ev_map), 0);
    done = 1;
    finish_run();
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule